// File: doc/BRIEF.md
# Serial ROM Checksum Generator

This block holds a 64-word by 16-bit configuration image for a network adapter's serial ROM and patches the two checksums that such an image carries. Software or a loader fills the image through a simple word write port while the block is idle. It then pulses `start`, and the block walks the image one bit per clock, computing two checksums in turn.

The first checksum is an 8-bit CRC over the identification block. It covers the first eight words and the high byte of word 8, and its result becomes the low byte of word 8. The second checksum is a 32-bit CRC over the first 126 bytes of the image, which includes the freshly patched byte. That CRC is bit-reversed and inverted, and its low 16 bits become word 63. When both write-backs are in place, `done` pulses for one cycle. The finished image can be read back through a combinational read port at any time.

Top module: `srom_csum_gen`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are low and every image word reads as 0x0000.
- R2: While `busy` is low, a cycle with `wr_en` high stores `wr_data` into word `wr_addr`. `rd_data` always shows word `rd_addr` combinationally.
- R3: The identification CRC is 8 bits wide. It starts at 0xFF and shifts left, with feedback equal to the data bit XOR the CRC bit 7. When the feedback is 1, the shifted value is XORed with 0x07. The data bits are words 0 to 7 followed by bits 15..8 of word 8, each word taken from bit 15 downward (136 bits). The result replaces bits 7..0 of word 8, and bits 15..8 of word 8 are kept.
- R4: The image CRC is 32 bits wide. It starts at 0xFFFFFFFF and shifts left with polynomial 0x04C11DB7, using the same feedback rule as R3. Its data is bytes 0 to 125, where byte 2k is bits 7..0 of word k and byte 2k+1 is bits 15..8, each byte taken least significant bit first. It runs after the R3 write-back, so it sees the patched byte.
- R5: Word 63 becomes bits 15..0 of the bitwise inverse of the bit-reversed final R4 value, so that result bit i is the inverse of CRC bit 31-i.
- R6: A run changes no word other than word 8 (low byte) and word 63.
- R7: `start` seen while `busy` is low launches a run. `busy` is high from the next cycle, and `done` is high for exactly one cycle, 1146 cycles after the launching edge. `busy` falls in the cycle after `done`.
- R8: `start` while `busy` is high has no effect: neither the timing nor the result changes.
- R9: `wr_en` while `busy` is high is ignored, and the addressed word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a checksum run when idle |
| wr_en | input | 1 | Image word write enable (idle only) |
| wr_addr | input | 6 | Image word write address |
| wr_data | input | 16 | Image word write data |
| rd_addr | input | 6 | Image word read address |
| rd_data | output | 16 | Image word at `rd_addr` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when both checksums are written |

## Verification
The checker assumes that `start` may arrive at any time, including mid-run, and that reset is held for at least one clock before the first run. It counts cycles from each accepted `start` to check the fixed run length. Its properties depend on no image contents, so random images need no constraint. The stimulus fills whole images from a seeded generator, plus all-zero and all-ones images. On alternate runs it deliberately pulses `start` and writes a conflicting word during the run. This exercises the lockout behaviour that the properties and the bench both expect to hold.

// File: rtl/srom_csum_pkg.sv
// Shared types and helpers for the serial ROM checksum generator.
// Assumes 16-bit image words made of two little-endian bytes.
package srom_csum_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_ID_WB,
        ST_SUM,
        ST_SUM_WB,
        ST_DONE
    } seq_state_e;

    // Bit-reverse a 32-bit CRC, invert it and keep the low half.
    function automatic logic [15:0] fold_sum(input logic [31:0] c);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            r[i] = c[31-i];
        end
        return ~r[15:0];
    endfunction

endpackage

// File: rtl/srom_crc_lfsr.sv
// Bit-serial left-shifting CRC register.
// Feedback is the data bit XOR the register MSB. The polynomial is applied
// on feedback. 'clear' loads INIT and takes priority over 'shift'.
module srom_crc_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h07,
    parameter logic [W-1:0] INIT = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] crc
);

    logic         fb;
    logic [W-1:0] nxt;

    assign fb = din ^ crc[W-1];

    // Per-bit next value: shifted-in bit plus polynomial tap.
    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == 0) begin : g_lsb
            assign nxt[i] = POLY[i] & fb;
        end else begin : g_mid
            assign nxt[i] = crc[i-1] ^ (POLY[i] & fb);
        end
    end

    // CRC state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= INIT;
        end else if (clear) begin
            crc <= INIT;
        end else if (shift) begin
            crc <= nxt;
        end
    end

endmodule

// File: rtl/srom_image_ram.sv
// Register-based image store with one host port and one engine port.
// Reads are combinational. An engine write wins over a host write to the same
// cycle; the caller gates host writes while a run is active.
module srom_image_ram #(
    parameter int WORDS = 64,
    parameter int AW    = 6,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_waddr,
    input  logic [DW-1:0] host_wdata,
    input  logic [AW-1:0] host_raddr,
    output logic [DW-1:0] host_rdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [DW-1:0] eng_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [DW-1:0] eng_wdata
);

    logic [DW-1:0] words [WORDS];

    assign host_rdata = words[host_raddr];
    assign eng_rdata  = words[eng_raddr];

    // Word storage with engine-first write priority.
    always_ff @(posedge clk) begin
        for (int k = 0; k < WORDS; k++) begin
            if (!rst_n) begin
                words[k] <= '0;
            end else if (eng_we && (eng_waddr == AW'(k))) begin
                words[k] <= eng_wdata;
            end else if (host_we && (host_waddr == AW'(k))) begin
                words[k] <= host_wdata;
            end
        end
    end

endmodule

// File: rtl/srom_csum_seq.sv
// Sequencer: walks the identification bits, patches word ID_WORDS, then walks
// the checksummed bytes and patches SUM_SLOT. One data bit per clock.
// Assumes 16-bit words; a shared bit counter gives word = cnt/16 in both
// phases, with bit 15-cnt[3:0] in the first phase and cnt[3:0] in the second.
module srom_csum_seq
    import srom_csum_pkg::*;
#(
    parameter int WORDS      = 64,
    parameter int AW         = 6,
    parameter int ID_WORDS   = 8,
    parameter int CSUM_BYTES = 126,
    parameter int SUM_SLOT   = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] eng_rdata,
    input  logic [7:0]        crc8,
    input  logic [31:0]       crc32,
    output logic [AW-1:0]     eng_raddr,
    output logic              eng_we,
    output logic [AW-1:0]     eng_waddr,
    output logic [WORD_W-1:0] eng_wdata,
    output logic              crc_clear,
    output logic              crc8_shift,
    output logic              crc32_shift,
    output logic              data_bit,
    output logic              busy,
    output logic              done
);

    localparam int ID_BITS  = ID_WORDS * WORD_W + BYTE_W;
    localparam int SUM_BITS = CSUM_BYTES * BYTE_W;
    localparam int MAX_BITS = (ID_BITS > SUM_BITS) ? ID_BITS : SUM_BITS;
    localparam int CW       = $clog2(MAX_BITS + 1);
    localparam logic [AW-1:0] ID_ADDR  = AW'(ID_WORDS);
    localparam logic [AW-1:0] SUM_ADDR = AW'(SUM_SLOT);

    seq_state_e    state;
    logic [CW-1:0] bit_cnt;
    logic [AW-1:0] walk_addr;
    logic          id_last;
    logic          sum_last;

    assign walk_addr = AW'(bit_cnt >> 4);
    assign id_last   = (bit_cnt == CW'(ID_BITS - 1));
    assign sum_last  = (bit_cnt == CW'(SUM_BITS - 1));
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
    assign crc_clear = (state == ST_IDLE) && start;

    // Memory addressing, bit selection and write-back data per state.
    always_comb begin
        eng_raddr   = walk_addr;
        eng_we      = 1'b0;
        eng_waddr   = ID_ADDR;
        eng_wdata   = '0;
        crc8_shift  = 1'b0;
        crc32_shift = 1'b0;
        data_bit    = 1'b0;
        case (state)
            ST_ID: begin
                data_bit   = eng_rdata[~bit_cnt[3:0]];
                crc8_shift = 1'b1;
            end
            ST_ID_WB: begin
                eng_raddr = ID_ADDR;
                eng_we    = 1'b1;
                eng_waddr = ID_ADDR;
                eng_wdata = {eng_rdata[WORD_W-1:BYTE_W], crc8};
            end
            ST_SUM: begin
                data_bit    = eng_rdata[bit_cnt[3:0]];
                crc32_shift = 1'b1;
            end
            ST_SUM_WB: begin
                eng_raddr = SUM_ADDR;
                eng_we    = 1'b1;
                eng_waddr = SUM_ADDR;
                eng_wdata = fold_sum(crc32);
            end
            default: begin
            end
        endcase
    end

    // Phase sequencing and bit counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    if (start) state <= ST_ID;
                end
                ST_ID: begin
                    if (id_last) begin
                        bit_cnt <= '0;
                        state   <= ST_ID_WB;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_ID_WB: state <= ST_SUM;
                ST_SUM: begin
                    if (sum_last) begin
                        bit_cnt <= '0;
                        state   <= ST_SUM_WB;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_SUM_WB: state <= ST_DONE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srom_csum_gen.sv
// Top: serial ROM image store plus checksum patcher.
// Host writes are accepted only while idle; start is ignored while busy.
module srom_csum_gen #(
    parameter int WORDS      = 64,
    parameter int ID_WORDS   = 8,
    parameter int CSUM_BYTES = 126,
    parameter int SUM_SLOT   = 63
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_addr,
    input  logic [15:0]              wr_data,
    input  logic [$clog2(WORDS)-1:0] rd_addr,
    output logic [15:0]              rd_data,
    output logic                     busy,
    output logic                     done
);

    localparam int AW = $clog2(WORDS);

    logic [15:0]   eng_rdata;
    logic [15:0]   eng_wdata;
    logic [AW-1:0] eng_raddr;
    logic [AW-1:0] eng_waddr;
    logic          eng_we;
    logic          crc_clear;
    logic          crc8_shift;
    logic          crc32_shift;
    logic          data_bit;
    logic [7:0]    crc8;
    logic [31:0]   crc32;

    srom_image_ram #(.WORDS(WORDS), .AW(AW), .DW(16)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (wr_en && !busy),
        .host_waddr (wr_addr),
        .host_wdata (wr_data),
        .host_raddr (rd_addr),
        .host_rdata (rd_data),
        .eng_raddr  (eng_raddr),
        .eng_rdata  (eng_rdata),
        .eng_we     (eng_we),
        .eng_waddr  (eng_waddr),
        .eng_wdata  (eng_wdata)
    );

    srom_csum_seq #(
        .WORDS(WORDS), .AW(AW), .ID_WORDS(ID_WORDS),
        .CSUM_BYTES(CSUM_BYTES), .SUM_SLOT(SUM_SLOT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .eng_rdata   (eng_rdata),
        .crc8        (crc8),
        .crc32       (crc32),
        .eng_raddr   (eng_raddr),
        .eng_we      (eng_we),
        .eng_waddr   (eng_waddr),
        .eng_wdata   (eng_wdata),
        .crc_clear   (crc_clear),
        .crc8_shift  (crc8_shift),
        .crc32_shift (crc32_shift),
        .data_bit    (data_bit),
        .busy        (busy),
        .done        (done)
    );

    srom_crc_lfsr #(.W(8), .POLY(8'h07), .INIT(8'hFF)) u_crc_id (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .shift (crc8_shift),
        .din   (data_bit),
        .crc   (crc8)
    );

    srom_crc_lfsr #(.W(32), .POLY(32'h04C11DB7), .INIT(32'hFFFFFFFF)) u_crc_img (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .shift (crc32_shift),
        .din   (data_bit),
        .crc   (crc32)
    );

endmodule

// File: rtl/srom_csum_chk.sv
// Protocol checker for srom_csum_gen: run launch, lockout, run length and the
// single-cycle done pulse. Bound to every instance of the top.
module srom_csum_chk #(
    parameter int ID_WORDS   = 8,
    parameter int CSUM_BYTES = 126
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done
);

    localparam int RUN_LEN = ID_WORDS * 16 + 8 + 1 + CSUM_BYTES * 8 + 1;
    localparam int LW      = $clog2(RUN_LEN + 1) + 1;

    logic [LW-1:0] lat_cnt;
    logic          rst_seen;

    // Cycles elapsed since the launching start edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                lat_cnt <= '0;
        else if (start && !busy)   lat_cnt <= '0;
        else if (busy)             lat_cnt <= lat_cnt + 1'b1;
    end

    // Remembers that the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // R1: idle outputs right after reset.
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            p_reset_idle_r1: assert (!busy && !done)
                else $error("busy/done high after reset");
        end
    end

    p_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_run_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == LW'(RUN_LEN)));

    p_busy_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind srom_csum_gen srom_csum_chk #(.ID_WORDS(ID_WORDS), .CSUM_BYTES(CSUM_BYTES)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done)
);

// File: tb/srom_csum_gen_tb.sv
module srom_csum_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_LEN    = 8 * 16 + 8 + 1 + 126 * 8 + 1;
    localparam int N_CASES    = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;

    logic [15:0] img [64];
    logic [15:0] expv [64];

    srom_csum_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] want);
        n_checks++;
        if (act !== want) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, want);
        end
    endtask

    function automatic logic [7:0] ref_crc8(input logic [15:0] im [64]);
        logic [7:0] c = 8'hFF;
        for (int w = 0; w <= 8; w++) begin
            for (int k = 0; k < ((w == 8) ? 8 : 16); k++) begin
                logic fb = im[w][15-k] ^ c[7];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
        return c;
    endfunction

    function automatic logic [15:0] ref_sum(input logic [15:0] im [64]);
        logic [31:0] c = 32'hFFFFFFFF;
        logic [31:0] r;
        for (int i = 0; i < 126; i++) begin
            logic [7:0] b = i[0] ? im[i>>1][15:8] : im[i>>1][7:0];
            for (int k = 0; k < 8; k++) begin
                logic fb = b[k] ^ c[31];
                c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
            end
        end
        for (int i = 0; i < 32; i++) r[i] = c[31-i];
        return ~r[15:0];
    endfunction

    task automatic build_expected();
        for (int i = 0; i < 64; i++) expv[i] = img[i];
        expv[8][7:0] = ref_crc8(expv);
        expv[63] = ref_sum(expv);
    endtask

    task automatic load_image();
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 6'(i); wr_data = img[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_word(input int a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = 6'(a);
        #1 v = rd_data;
    endtask

    // Run one image through the block; optionally disturb it mid-run.
    task automatic run_case(input bit disturb);
        int k;
        logic [15:0] v;
        bit ok6;
        load_image();
        read_word(5, v);
        check("R2 write/readback", {16'h0, v}, {16'h0, img[5]});
        build_expected();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 5000) begin
            @(negedge clk);
            k++;
            if (disturb && k == 300) begin
                start = 1'b1; wr_en = 1'b1; wr_addr = 6'd0; wr_data = ~img[0];
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
        end
        check("R7 run length", 32'(k), 32'(RUN_LEN));
        check("R7 busy with done", {31'h0, busy}, 32'h1);
        @(negedge clk);
        check("R7 done single cycle", {30'h0, done, busy}, 32'h0);
        read_word(8, v);
        check("R3 word 8", {16'h0, v}, {16'h0, expv[8]});
        read_word(63, v);
        check("R4 R5 word 63", {16'h0, v}, {16'h0, expv[63]});
        ok6 = 1'b1;
        for (int i = 1; i < 63; i++) begin
            if (i != 8) begin
                read_word(i, v);
                if (v !== img[i]) ok6 = 1'b0;
            end
        end
        check("R6 untouched words", {31'h0, ok6}, 32'h1);
        read_word(0, v);
        check(disturb ? "R9 busy write ignored" : "R6 word 0", {16'h0, v}, {16'h0, img[0]});
        if (disturb) begin
            repeat (3) @(negedge clk);
            check("R8 start while busy ignored", {30'h0, busy, done}, 32'h0);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        bit zero_ok;
        void'($urandom(32'h5EED_0C5C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset busy/done", {30'h0, busy, done}, 32'h0);
        zero_ok = 1'b1;
        for (int i = 0; i < 64; i++) begin
            read_word(i, v);
            if (v !== 16'h0) zero_ok = 1'b0;
        end
        check("R1 reset image zero", {31'h0, zero_ok}, 32'h1);

        for (int i = 0; i < 64; i++) img[i] = 16'h0000;
        run_case(1'b0);
        for (int i = 0; i < 64; i++) img[i] = 16'hFFFF;
        run_case(1'b1);
        for (int c = 0; c < N_CASES; c++) begin
            for (int i = 0; i < 64; i++) img[i] = 16'($urandom);
            run_case(c[0]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule